// File: doc/BRIEF.md
# Code-Protect-Aware Image Checksum Engine

This block produces the 16-bit checksum of a program image held in a 1K-word or 2K-word program memory. The rules that set which words count depend on the code-protection setting carried in the 14-bit configuration word. After a start pulse the engine reads the configuration, decides which address range is still readable, and streams those words in through a memory read port. The port has one cycle of read latency. The engine adds the words into a running sum that wraps at 2^16, together with the configuration word and, when protection is on, a value packed from the four ID words.

The top word of the memory holds an oscillator calibration value. It is never read and never summed. With protection off, every word below the calibration word is summed. When the upper part of memory is protected, only the readable low region is summed. With full protection, no memory word is read at all. The configuration word repeats its two-bit protection code in four places. If the copies disagree, the block treats the image as unprotected and raises a mismatch flag. The result appears together with a one-cycle done pulse and stays on the output until the next run.

Top module: `cksum_engine`

## Requirements
- R1: The two-bit protection code sits at configuration bits 13:12, 11:10, 9:8 and 6:5. When all four copies are equal, that value is the code. When any copy differs, the code is taken as 11 (off) and `cp_mismatch` reads 1 from the end of that run's first cycle until the next accepted start.
- R2: Code 11 (off): the sum covers words 0x000 to 0x3FE for a 1K part (`big_mem`=0) or 0x000 to 0x7FE for a 2K part (`big_mem`=1), plus the configuration word ANDed with 0x3FFF. No ID value is added.
- R3: Code 01: the sum covers words 0x000 to 0x1FF, plus the masked configuration word and the packed ID value.
- R4: Code 10: the sum covers 0x000 to 0x3FF on a 2K part and 0x000 to 0x3FE on a 1K part, plus the masked configuration word and the packed ID value.
- R5: Code 00: the result is the masked configuration word plus the packed ID value, and `mem_rd` is never asserted during the run.
- R6: The packed ID value is {id0[3:0], id1[3:0], id2[3:0], id3[3:0]}, so id0 supplies the most significant nibble. For example, 0x12, 0x37, 0x4 and 0x26 give 0x2746.
- R7: The sum is taken modulo 2^16, and carries out of bit 15 are discarded.
- R8: Reads go out as `mem_rd` high with `mem_addr` starting at 0 and rising by one on each consecutive cycle, one read per summed word. `mem_data` is taken on the clock edge after the read. The calibration address (0x3FF or 0x7FF) is never read.
- R9: Let N be the number of summed words. `done` is high for exactly one cycle, after the (N+1)th clock edge that follows the edge sampling `start`. `sum_out` then holds the result until the next accepted start.
- R10: A `start` pulse that arrives while a run is in progress is ignored, and the result of the run in progress is unchanged. Changes to `cfg_word` after the start edge have no effect on the run's range.
- R11: While reset is held, `done`, `mem_rd`, `cp_mismatch` and `sum_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a checksum run (sampled while idle) |
| big_mem | input | 1 | Memory size select: 0 = 1K words, 1 = 2K words |
| cfg_word | input | 14 | Configuration word |
| id0 | input | 14 | ID word 0 (most significant nibble source) |
| id1 | input | 14 | ID word 1 |
| id2 | input | 14 | ID word 2 |
| id3 | input | 14 | ID word 3 (least significant nibble source) |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 11 | Memory read address |
| mem_data | input | 14 | Read data, valid the cycle after the strobe |
| sum_out | output | 16 | Checksum result |
| done | output | 1 | One-cycle result-valid pulse |
| cp_mismatch | output | 1 | Replicated protection codes disagreed |

## Verification
The timing of the results is fixed by the range size. The first read strobe appears after the start edge. Each read's data is summed one edge later. `done` rises after edge N+1 counted from the start edge, so a fully protected run finishes after a single edge. The bench works out N and the expected sum from its own model. It then compares `done` against that one expected cycle on every clock of the run and checks `sum_out`, `cp_mismatch` and the read count once `done` has passed. A monitor at each clock edge records the order of the read addresses and any touch of the calibration address. These records are judged after the run.

// File: rtl/cksum_pkg.sv
package cksum_pkg;
  localparam int ADDR_W    = 11;
  localparam int DATA_W    = 14;
  localparam int SUM_W     = 16;
  localparam int NUM_IDS   = 4;
  localparam int NIB_W     = 4;
  localparam int NUM_PAIRS = 4;
  localparam int PAIR_W    = 2;

  // low bit position of each replicated protection pair in the configuration word
  localparam int PAIR_LO [NUM_PAIRS] = '{12, 10, 8, 5};

  localparam logic [ADDR_W-1:0] SMALL_TOP = ADDR_W'(1024 - 1);
  localparam logic [ADDR_W-1:0] LARGE_TOP = ADDR_W'(2048 - 1);
  localparam logic [ADDR_W-1:0] SPLIT_LO  = ADDR_W'(512 - 1);
  localparam logic [ADDR_W-1:0] SPLIT_HI  = ADDR_W'(1024 - 1);
  localparam logic [DATA_W-1:0] CFG_MASK  = {DATA_W{1'b1}};

  typedef enum logic [1:0] {
    PROT_ALL       = 2'b00,
    PROT_ABOVE_200 = 2'b01,
    PROT_ABOVE_400 = 2'b10,
    PROT_OFF       = 2'b11
  } prot_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RUN   = 2'd1,
    SQ_DRAIN = 2'd2,
    SQ_FIN   = 2'd3
  } seq_e;
endpackage

// File: rtl/cksum_cp_decode.sv
module cksum_cp_decode
  import cksum_pkg::*;
(
  input  logic [PAIR_W-1:0] pair_i [NUM_PAIRS],
  input  logic              big_i,
  output prot_e             prot_o,
  output logic              mismatch_o,
  output logic [ADDR_W-1:0] last_o,
  output logic              empty_o
);
  logic              agree;
  logic [ADDR_W-1:0] cap;

  always_comb begin
    agree = 1'b1;
    for (int i = 1; i < NUM_PAIRS; i++) begin
      if (pair_i[i] != pair_i[0]) agree = 1'b0;
    end
  end

  assign mismatch_o = !agree;
  assign prot_o     = agree ? prot_e'(pair_i[0]) : PROT_OFF;
  // highest summable word sits just below the calibration word
  assign cap        = (big_i ? LARGE_TOP : SMALL_TOP) - 1'b1;

  always_comb begin
    last_o  = cap;
    empty_o = 1'b0;
    case (prot_o)
      PROT_OFF:       last_o = cap;
      PROT_ABOVE_400: last_o = (SPLIT_HI < cap) ? SPLIT_HI : cap;
      PROT_ABOVE_200: last_o = SPLIT_LO;
      PROT_ALL: begin
        last_o  = '0;
        empty_o = 1'b1;
      end
      default: last_o = cap;
    endcase
  end
endmodule

// File: rtl/cksum_id_pack.sv
module cksum_id_pack
  import cksum_pkg::*;
(
  input  logic [DATA_W-1:0] id_i [NUM_IDS],
  output logic [SUM_W-1:0]  packed_o
);
  localparam logic [DATA_W-1:0] NIB_MASK = DATA_W'((1 << NIB_W) - 1);

  logic [SUM_W-1:0] term [NUM_IDS];

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_nib
    assign term[g] = SUM_W'(id_i[g] & NIB_MASK) << ((NUM_IDS - 1 - g) * NIB_W);
  end

  always_comb begin
    packed_o = '0;
    for (int i = 0; i < NUM_IDS; i++) packed_o = packed_o | term[i];
  end
endmodule

// File: rtl/cksum_addr_seq.sv
module cksum_addr_seq
  import cksum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              empty_i,
  input  logic [ADDR_W-1:0] last_i,
  output logic              load_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              take_o,
  output logic              done_o
);
  seq_e              state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] last_q;
  logic              take_q, take_d;
  logic              addr_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    load_o  = 1'b0;
    take_d  = (state_q == SQ_RUN);
    case (state_q)
      SQ_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          addr_d  = '0;
          state_d = empty_i ? SQ_DRAIN : SQ_RUN;
        end
      end
      SQ_RUN: begin
        if (addr_q == last_q) state_d = SQ_DRAIN;
        else                  addr_d  = addr_q + 1'b1;
      end
      SQ_DRAIN: state_d = SQ_FIN;
      SQ_FIN:   state_d = SQ_IDLE;
      default:  state_d = SQ_IDLE;
    endcase
  end

  assign addr_en = load_o || (state_q == SQ_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      take_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      take_q  <= take_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= '0;
    else if (load_o) last_q <= last_i;
  end

  assign mem_rd_o   = (state_q == SQ_RUN);
  assign mem_addr_o = addr_q;
  assign take_o     = take_q;
  assign done_o     = (state_q == SQ_FIN);

  assert_addr_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o && $past(mem_rd_o)) |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!mem_rd_o && !take_o));
endmodule

// File: rtl/cksum_accum.sv
module cksum_accum
  import cksum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SUM_W-1:0]  init_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [SUM_W-1:0]  sum_o
);
  logic [SUM_W-1:0] acc_q, acc_d;
  logic             acc_en;

  assign acc_en = load_i || take_i;

  // carries past the top bit fall away (R7)
  always_comb begin
    if (load_i) acc_d = init_i;
    else        acc_d = acc_q + SUM_W'(data_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign sum_o = acc_q;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !take_i) |=> $stable(acc_q));
endmodule

// File: rtl/cksum_engine.sv
module cksum_engine
  import cksum_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              big_mem,
  input  logic [DATA_W-1:0] cfg_word,
  input  logic [DATA_W-1:0] id0,
  input  logic [DATA_W-1:0] id1,
  input  logic [DATA_W-1:0] id2,
  input  logic [DATA_W-1:0] id3,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_data,
  output logic [SUM_W-1:0]  sum_out,
  output logic              done,
  output logic              cp_mismatch
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [PAIR_W-1:0] pairs [NUM_PAIRS];
  logic [DATA_W-1:0] ids   [NUM_IDS];
  prot_e             prot;
  logic              mism_c;
  logic [ADDR_W-1:0] last_c;
  logic              empty_c;
  logic [SUM_W-1:0]  id_sum;
  logic [SUM_W-1:0]  init_c;
  logic              load;
  logic              take;
  logic              mism_q;
  logic [ADDR_W-1:0] calib_q, calib_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign pairs[g] = cfg_word[PAIR_LO[g] +: PAIR_W];
  end

  assign ids[0] = id0;
  assign ids[1] = id1;
  assign ids[2] = id2;
  assign ids[3] = id3;

  cksum_cp_decode u_decode (
    .pair_i     (pairs),
    .big_i      (big_mem),
    .prot_o     (prot),
    .mismatch_o (mism_c),
    .last_o     (last_c),
    .empty_o    (empty_c)
  );

  cksum_id_pack u_idpack (
    .id_i     (ids),
    .packed_o (id_sum)
  );

  assign init_c = SUM_W'(cfg_word & CFG_MASK) + ((prot != PROT_OFF) ? id_sum : '0);

  cksum_addr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start_i    (start),
    .empty_i    (empty_c),
    .last_i     (last_c),
    .load_o     (load),
    .mem_rd_o   (mem_rd),
    .mem_addr_o (mem_addr),
    .take_o     (take),
    .done_o     (done)
  );

  cksum_accum u_accum (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (load),
    .init_i (init_c),
    .take_i (take),
    .data_i (mem_data),
    .sum_o  (sum_out)
  );

  assign calib_d = big_mem ? LARGE_TOP : SMALL_TOP;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mism_q  <= 1'b0;
      calib_q <= SMALL_TOP;
    end else if (load) begin
      mism_q  <= mism_c;
      calib_q <= calib_d;
    end
  end

  assign cp_mismatch = mism_q;

  assert_skip_calib_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_rd |-> (mem_addr != calib_q));

  assert_full_prot_no_read_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load && prot == PROT_ALL) |=> !mem_rd);

  assert_mismatch_off_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (load && mism_c) |-> (prot == PROT_OFF && !empty_c));
endmodule

// File: tb/cksum_engine_bench.sv
module cksum_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        big_mem;
  logic [13:0] cfg_word, id0, id1, id2, id3;
  logic        mem_rd;
  logic [10:0] mem_addr;
  logic [13:0] mem_data;
  logic [15:0] sum_out;
  logic        done;
  logic        cp_mismatch;

  int tests = 0;
  int fails = 0;
  int rd_count, next_exp, calib_hits, order_err;
  int calib_addr;

  always #2 clk = ~clk;

  cksum_engine u_cksum_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .big_mem(big_mem),
    .cfg_word(cfg_word), .id0(id0), .id1(id1), .id2(id2), .id3(id3),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .sum_out(sum_out), .done(done), .cp_mismatch(cp_mismatch)
  );

  function automatic logic [13:0] memf(input int a);
    int v;
    v = (a * 197 + 89) ^ (a << 5);
    return 14'(v);
  endfunction

  // memory with one cycle of read latency, plus a read monitor
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_data <= memf(int'(mem_addr));
      if (int'(mem_addr) != next_exp) order_err++;
      if (int'(mem_addr) == calib_addr) calib_hits++;
      next_exp++;
      rd_count++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ref_model(input bit big, input logic [13:0] cfg,
                           input logic [13:0] a0, a1, a2, a3,
                           output int n, output logic [15:0] s, output bit mm);
    logic [1:0] code;
    int acc;
    mm = !((cfg[13:12] == cfg[11:10]) && (cfg[11:10] == cfg[9:8]) && (cfg[9:8] == cfg[6:5]));
    code = mm ? 2'b11 : cfg[13:12];
    case (code)
      2'b11:   n = big ? 2047 : 1023;
      2'b10:   n = big ? 1024 : 1023;
      2'b01:   n = 512;
      default: n = 0;
    endcase
    acc = int'(cfg);
    if (code != 2'b11) acc += int'({a0[3:0], a1[3:0], a2[3:0], a3[3:0]});
    for (int a = 0; a < n; a++) acc += int'(memf(a));
    s = 16'(acc);
  endtask

  task automatic run_case(input string req, input bit big, input logic [13:0] cfg,
                          input logic [13:0] a0, a1, a2, a3, input bit poke);
    int n;
    logic [15:0] exp_sum;
    bit mm;
    bit done_ok;
    int bad_k;
    ref_model(big, cfg, a0, a1, a2, a3, n, exp_sum, mm);
    @(negedge clk);
    big_mem = big; cfg_word = cfg; id0 = a0; id1 = a1; id2 = a2; id3 = a3;
    rd_count = 0; next_exp = 0; calib_hits = 0; order_err = 0;
    calib_addr = big ? 2047 : 1023;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    done_ok = 1'b1;
    bad_k = -1;
    for (int k = 1; k <= n + 3; k++) begin
      @(negedge clk);
      // R10: a late start and a changed configuration must not disturb the run
      if (poke && k == 3) begin
        start = 1'b1;
        cfg_word = 14'h0000;
      end else if (poke && k == 4) begin
        start = 1'b0;
      end
      // R9: done compared against the reference on every clock
      if (done !== (k == n + 1)) begin
        if (done_ok) bad_k = k;
        done_ok = 1'b0;
      end
    end
    check(done_ok, "R9", {req, " done timing (first bad cycle)"}, bad_k, n + 1);
    check(sum_out === exp_sum, req, "checksum", sum_out, exp_sum);
    check(rd_count == n, "R8", {req, " read count"}, rd_count, n);
    check(order_err == 0, "R8", {req, " address order"}, order_err, 0);
    check(calib_hits == 0, "R8", {req, " calibration word read"}, calib_hits, 0);
    check(cp_mismatch === mm, "R1", {req, " mismatch flag"}, cp_mismatch, mm);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; big_mem = 1'b0;
    cfg_word = '0; id0 = '0; id1 = '0; id2 = '0; id3 = '0;
    mem_data = '0;
    rd_count = 0; next_exp = 0; calib_hits = 0; order_err = 0; calib_addr = 1023;
    repeat (3) @(negedge clk);
    // R11: state while reset is held
    check(done === 1'b0, "R11", "done in reset", done, 0);
    check(mem_rd === 1'b0, "R11", "mem_rd in reset", mem_rd, 0);
    check(sum_out === 16'h0, "R11", "sum_out in reset", sum_out, 0);
    check(cp_mismatch === 1'b0, "R11", "cp_mismatch in reset", cp_mismatch, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 and R7: unprotected, sums wrap past 16 bits
    run_case("R2/R7", 1'b1, 14'h3FFF, 14'h3FFF, 14'h0ABC, 14'h1230, 14'h0005, 1'b0);
    run_case("R2", 1'b0, 14'h3FE2, 14'h0012, 14'h0037, 14'h0004, 14'h0026, 1'b0);
    // R3 with R6: packed IDs 0x2746 included
    run_case("R3/R6", 1'b1, 14'h15A5, 14'h0012, 14'h0037, 14'h0004, 14'h0026, 1'b0);
    run_case("R3", 1'b0, 14'h1533, 14'h3FFF, 14'h0ABC, 14'h1230, 14'h0005, 1'b0);
    // R4: upper half protected, 1K clipped below the calibration word
    run_case("R4", 1'b1, 14'h2ACC, 14'h0012, 14'h0037, 14'h0004, 14'h0026, 1'b0);
    run_case("R4", 1'b0, 14'h2A47, 14'h3FFF, 14'h0ABC, 14'h1230, 14'h0005, 1'b0);
    // R5: everything protected, no reads
    run_case("R5/R6", 1'b1, 14'h009F, 14'h0012, 14'h0037, 14'h0004, 14'h0026, 1'b0);
    run_case("R5", 1'b0, 14'h0080, 14'h3FFF, 14'h0ABC, 14'h1230, 14'h0005, 1'b0);
    // R1: one copy disagrees, treated as off
    run_case("R1", 1'b0, 14'h3F8A, 14'h0012, 14'h0037, 14'h0004, 14'h0026, 1'b0);
    // R10: start and configuration change while busy are ignored
    run_case("R10", 1'b1, 14'h15A5, 14'h3FFF, 14'h0ABC, 14'h1230, 14'h0005, 1'b1);
    // R1: agreeing copies clear the flag again
    run_case("R1/R3", 1'b1, 14'h15A5, 14'h0001, 14'h0002, 14'h0003, 14'h0004, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule